// File: doc/BRIEF.md
# Privileged Event-Delivery State Controller

This block holds the architectural state that a simplified processor changes when it takes an event and when it returns from one. The state is the current ring (supervisor or user), the current stack level (0 to 3), the active stack pointer, an active GS base and a kernel GS base, and an NMI-blocked flag. Each delivery pushes the outgoing stack level and stack pointer onto a small internal frame stack. Each successful return pops that frame, so nested events unwind in reverse order.

A delivery picks the higher of the current level and the level it asks for. When the level rises, the stack pointer is loaded from the register programmed for the new level. When the level stays the same, the stack pointer is kept. The GS registers swap only on transitions into or out of user mode. A standalone GS-swap request is rejected with an undefined-opcode fault while the mechanism is enabled. NMI blocking is cleared only by a return that asks for it.

Each request is sampled on a rising clock edge. The new state and any one-cycle fault pulse appear at the outputs after that edge. If several requests arrive in the same cycle, only the highest-priority one is acted on.

Top module: `evt_ctx_ctrl`

## Requirements
- R1: After a synchronous active-low reset the outputs are: supervisor ring (`in_user`=0), level 0, stack pointer 0, both GS registers 0, NMI unblocked, no fault, and an empty frame stack.
- R2: On a delivery the new level is max(current level, requested level). If the level rises, `cur_sp` is loaded from the register programmed for the new level. If it does not rise, `cur_sp` is unchanged.
- R3: A successful return restores the level and the full stack pointer that were in force just before the matching delivery, in last-in first-out order.
- R4: A delivery taken in user mode exchanges `gs_base` and `kgs_base` and enters the supervisor ring. A delivery taken in the supervisor ring leaves the ring and both GS registers unchanged.
- R5: A return with `ret_to_user`=1 enters user mode and exchanges the two GS registers. A return with `ret_to_user`=0 stays in the supervisor ring and swaps nothing.
- R6: A delivery with `dlv_nmi`=1 sets `nmi_blocked`. A successful return clears it only when `ret_nmi_unblk`=1 and otherwise leaves it unchanged.
- R7: A GS-swap request with `mech_en`=1 pulses `flt_undef` for one cycle and changes no state. With `mech_en`=0 it exchanges the two GS registers.
- R8: A kernel-GS load writes `kgs_load_data` into `kgs_base` and leaves `gs_base` unchanged.
- R9: A delivery while four frames are held pulses `flt_overflow` and changes no state.
- R10: A return with an empty frame stack, or any return issued in user mode, pulses `flt_return` and changes no state.
- R11: Simultaneous requests are served in this priority order: delivery, return, GS swap, kernel-GS load. The lower-priority requests are ignored and raise no fault.
- R12: Writing a level's stack-pointer register does not change `cur_sp`. The written value is used by the next delivery that rises to that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mech_en | input | 1 | Mechanism enabled; makes standalone GS swap fault |
| sp_wr_en | input | 1 | Write a per-level stack-pointer register |
| sp_wr_lvl | input | 2 | Level whose register is written |
| sp_wr_data | input | SP_W | Stack-pointer value to program |
| dlv_req | input | 1 | Event-delivery request |
| dlv_lvl | input | 2 | Requested stack level |
| dlv_nmi | input | 1 | Delivered event is an NMI |
| ret_req | input | 1 | Event-return request |
| ret_to_user | input | 1 | 1 = return to user, 0 = return to supervisor |
| ret_nmi_unblk | input | 1 | Return clears NMI blocking |
| gs_swap_req | input | 1 | Standalone GS-swap request |
| kgs_load_req | input | 1 | Kernel-GS load request |
| kgs_load_data | input | GS_W | Kernel-GS load operand |
| in_user | output | 1 | 1 = user ring, 0 = supervisor ring |
| cur_lvl | output | 2 | Current stack level |
| cur_sp | output | SP_W | Active stack pointer |
| gs_base | output | GS_W | Active GS base |
| kgs_base | output | GS_W | Kernel GS base |
| nmi_blocked | output | 1 | NMI blocked flag |
| flt_undef | output | 1 | Undefined-opcode fault pulse |
| flt_overflow | output | 1 | Frame-stack overflow pulse |
| flt_return | output | 1 | Illegal-return fault pulse |

## Verification
The assertions check on every cycle that:
- a delivery never lowers the level;
- a delivery always ends in the supervisor ring;
- an accepted swap exchanges the GS pair exactly;
- a kernel-GS load never disturbs `gs_base`;
- a return without the unblock bit keeps `nmi_blocked`;
- every fault pulse comes with frozen state;
- at most one fault fires at a time.

Only the bench's scenarios can show the following:
- the actual stack-pointer values chosen on a level rise;
- the exact frames restored by a chain of nested returns;
- the GS values after a user round trip;
- that a programmed level register takes effect only on a later delivery.

// File: rtl/evt_ctx_pkg.sv
// Shared types and helpers for the event-delivery state controller.
// Assumes exactly four stack levels; the level width is derived from that count.
package evt_ctx_pkg;
    localparam int NUM_LVL = 4;
    localparam int LVL_W   = $clog2(NUM_LVL);

    typedef logic [LVL_W-1:0] lvl_t;

    // Operation chosen for the cycle after priority resolution
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_DLV,
        OP_RET,
        OP_SWAP,
        OP_LDK
    } op_e;

    // Higher of two stack levels
    function automatic lvl_t lvl_max(input lvl_t a, input lvl_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/evt_sp_bank.sv
// Per-level programmable stack-pointer registers, one per stack level.
// A write changes only the addressed level. The read port is combinational,
// so a same-cycle write is not seen by a read in that cycle.
module evt_sp_bank
    import evt_ctx_pkg::*;
#(
    parameter int SP_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  lvl_t            wr_lvl,
    input  logic [SP_W-1:0] wr_data,
    input  lvl_t            rd_lvl,
    output logic [SP_W-1:0] rd_data
);
    logic [NUM_LVL-1:0][SP_W-1:0] sp_flat;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        logic [SP_W-1:0] sp_q;
        // hold the stack-pointer value programmed for level g
        always_ff @(posedge clk) begin
            if (!rst_n)
                sp_q <= '0;
            else if (wr_en && (wr_lvl == lvl_t'(g)))
                sp_q <= wr_data;
        end
        assign sp_flat[g] = sp_q;
    end

    // select the register of the requested level
    assign rd_data = sp_flat[rd_lvl];

    AST_SP_WR_TAKES : assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sp_flat[$past(wr_lvl)] == $past(wr_data)); // R12
endmodule

// File: rtl/evt_frame_lifo.sv
// Last-in first-out store for saved contexts (stack level plus stack pointer).
// The caller must never push when full or pop when empty, and never both at once.
module evt_frame_lifo #(
    parameter int DEPTH = 4,
    parameter int W     = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] top_data,
    output logic         full,
    output logic         empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0]          cnt_q;
    logic [DEPTH-1:0][W-1:0]   ent_flat;
    logic [IDX_W-1:0]          rd_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [W-1:0] ent_q;
        // capture a frame when it is pushed into slot g
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q <= '0;
            else if (push && (cnt_q == CNT_W'(g)))
                ent_q <= push_data;
        end
        assign ent_flat[g] = ent_q;
    end

    // track the number of held frames
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push)
            cnt_q <= cnt_q + 1'b1;
        else if (pop)
            cnt_q <= cnt_q - 1'b1;
    end

    // expose occupancy and the most recent frame
    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign rd_idx   = IDX_W'(cnt_q - 1'b1);
    assign top_data = empty ? '0 : ent_flat[rd_idx];

    AST_LIFO_PUSH_FULL : assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R9
    AST_LIFO_POP_EMPTY : assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R10
    AST_LIFO_ONE_OP : assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop)); // R11
endmodule

// File: rtl/evt_gs_regs.sv
// Active GS base and kernel GS base pair with exchange and kernel-load operations.
// The caller must not request a swap and a load in the same cycle.
module evt_gs_regs #(
    parameter int GS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            swap,
    input  logic            load,
    input  logic [GS_W-1:0] load_data,
    output logic [GS_W-1:0] gs,
    output logic [GS_W-1:0] kgs
);
    // update the GS pair on an exchange or a kernel load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gs  <= '0;
            kgs <= '0;
        end else if (swap) begin
            gs  <= kgs;
            kgs <= gs;
        end else if (load) begin
            kgs <= load_data;
        end
    end

    AST_GS_SWAP_XCHG : assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (gs == $past(kgs)) && (kgs == $past(gs))); // R4
    AST_GS_LOAD_KEEP : assert property (@(posedge clk) disable iff (!rst_n)
        load |=> $stable(gs) && (kgs == $past(load_data))); // R8
endmodule

// File: rtl/evt_ctx_ctrl.sv
// Top of the event-delivery state controller. It resolves the requests by
// priority, moves the ring, stack level, stack pointer and NMI state, and
// drives the frame stack and the GS pair. Each request takes effect on the
// edge that samples it. Faults are registered pulses one cycle long.
module evt_ctx_ctrl
    import evt_ctx_pkg::*;
#(
    parameter int SP_W        = 32,
    parameter int GS_W        = 32,
    parameter int FRAME_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mech_en,
    input  logic             sp_wr_en,
    input  logic [LVL_W-1:0] sp_wr_lvl,
    input  logic [SP_W-1:0]  sp_wr_data,
    input  logic             dlv_req,
    input  logic [LVL_W-1:0] dlv_lvl,
    input  logic             dlv_nmi,
    input  logic             ret_req,
    input  logic             ret_to_user,
    input  logic             ret_nmi_unblk,
    input  logic             gs_swap_req,
    input  logic             kgs_load_req,
    input  logic [GS_W-1:0]  kgs_load_data,
    output logic             in_user,
    output logic [LVL_W-1:0] cur_lvl,
    output logic [SP_W-1:0]  cur_sp,
    output logic [GS_W-1:0]  gs_base,
    output logic [GS_W-1:0]  kgs_base,
    output logic             nmi_blocked,
    output logic             flt_undef,
    output logic             flt_overflow,
    output logic             flt_return
);
    localparam int FRAME_W = LVL_W + SP_W;

    op_e              op;
    logic             do_dlv, do_ret, ovf_hit, ret_bad, ud_hit;
    logic             gs_swap, gs_load;
    lvl_t             new_lvl, frm_lvl;
    logic [SP_W-1:0]  bank_sp, frm_sp;
    logic [FRAME_W-1:0] push_frame, top_frame;
    logic             lifo_full, lifo_empty;

    // pick one operation per cycle: delivery, return, swap, load
    always_comb begin
        op = OP_IDLE;
        if (dlv_req)
            op = OP_DLV;
        else if (ret_req)
            op = OP_RET;
        else if (gs_swap_req)
            op = OP_SWAP;
        else if (kgs_load_req)
            op = OP_LDK;
    end

    // qualify the chosen operation against the current state
    always_comb begin
        ovf_hit = (op == OP_DLV) && lifo_full;
        do_dlv  = (op == OP_DLV) && !lifo_full;
        ret_bad = (op == OP_RET) && (lifo_empty || in_user);
        do_ret  = (op == OP_RET) && !ret_bad;
        ud_hit  = (op == OP_SWAP) && mech_en;
        gs_swap = (do_dlv && in_user) || (do_ret && ret_to_user)
                || ((op == OP_SWAP) && !mech_en);
        gs_load = (op == OP_LDK);
    end

    assign new_lvl    = lvl_max(cur_lvl, dlv_lvl);
    assign push_frame = {cur_lvl, cur_sp};
    assign frm_lvl    = top_frame[FRAME_W-1 -: LVL_W];
    assign frm_sp     = top_frame[SP_W-1:0];

    evt_sp_bank #(.SP_W(SP_W)) i_sp_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sp_wr_en),
        .wr_lvl  (sp_wr_lvl),
        .wr_data (sp_wr_data),
        .rd_lvl  (new_lvl),
        .rd_data (bank_sp)
    );

    evt_frame_lifo #(.DEPTH(FRAME_DEPTH), .W(FRAME_W)) i_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_dlv),
        .push_data (push_frame),
        .pop       (do_ret),
        .top_data  (top_frame),
        .full      (lifo_full),
        .empty     (lifo_empty)
    );

    evt_gs_regs #(.GS_W(GS_W)) i_gs (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap      (gs_swap),
        .load      (gs_load),
        .load_data (kgs_load_data),
        .gs        (gs_base),
        .kgs       (kgs_base)
    );

    // move ring, level, stack pointer and NMI state on delivery or return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_user     <= 1'b0;
            cur_lvl     <= '0;
            cur_sp      <= '0;
            nmi_blocked <= 1'b0;
        end else if (do_dlv) begin
            in_user <= 1'b0;
            cur_lvl <= new_lvl;
            if (new_lvl != cur_lvl)
                cur_sp <= bank_sp;
            if (dlv_nmi)
                nmi_blocked <= 1'b1;
        end else if (do_ret) begin
            in_user <= ret_to_user;
            cur_lvl <= frm_lvl;
            cur_sp  <= frm_sp;
            if (ret_nmi_unblk)
                nmi_blocked <= 1'b0;
        end
    end

    // register the one-cycle fault pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_undef    <= 1'b0;
            flt_overflow <= 1'b0;
            flt_return   <= 1'b0;
        end else begin
            flt_undef    <= ud_hit;
            flt_overflow <= ovf_hit;
            flt_return   <= ret_bad;
        end
    end

    AST_DLV_NO_DROP : assert property (@(posedge clk) disable iff (!rst_n)
        do_dlv |=> cur_lvl >= $past(cur_lvl)); // R2
    AST_DLV_SUPER : assert property (@(posedge clk) disable iff (!rst_n)
        do_dlv |=> !in_user); // R4
    AST_RET_USER : assert property (@(posedge clk) disable iff (!rst_n)
        (do_ret && ret_to_user) |=> in_user); // R5
    AST_NMI_HOLD : assert property (@(posedge clk) disable iff (!rst_n)
        (do_ret && !ret_nmi_unblk) |=> nmi_blocked == $past(nmi_blocked)); // R6
    AST_UD_FROZEN : assert property (@(posedge clk) disable iff (!rst_n)
        flt_undef |-> $stable(gs_base) && $stable(kgs_base) && $stable(cur_sp)); // R7
    AST_OVF_FROZEN : assert property (@(posedge clk) disable iff (!rst_n)
        flt_overflow |-> $stable(cur_lvl) && $stable(cur_sp) && $stable(nmi_blocked)); // R9
    AST_RETF_FROZEN : assert property (@(posedge clk) disable iff (!rst_n)
        flt_return |-> $stable(cur_lvl) && $stable(cur_sp) && $stable(in_user)
                       && $stable(gs_base)); // R10
    AST_ONE_FAULT : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flt_undef, flt_overflow, flt_return})); // R11
endmodule

// File: tb/test_evt_ctx_ctrl.sv
module test_evt_ctx_ctrl;
    localparam int SP_W = 32;
    localparam int GS_W = 32;
    localparam int NVEC = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mech_en = 1'b1;
    logic sp_wr_en = 1'b0;
    logic [1:0] sp_wr_lvl = '0;
    logic [SP_W-1:0] sp_wr_data = '0;
    logic dlv_req = 1'b0, dlv_nmi = 1'b0;
    logic [1:0] dlv_lvl = '0;
    logic ret_req = 1'b0, ret_to_user = 1'b0, ret_nmi_unblk = 1'b0;
    logic gs_swap_req = 1'b0, kgs_load_req = 1'b0;
    logic [GS_W-1:0] kgs_load_data = '0;
    logic in_user, nmi_blocked, flt_undef, flt_overflow, flt_return;
    logic [1:0] cur_lvl;
    logic [SP_W-1:0] cur_sp;
    logic [GS_W-1:0] gs_base, kgs_base;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    evt_ctx_ctrl #(.SP_W(SP_W), .GS_W(GS_W), .FRAME_DEPTH(4)) i_evt_ctx_ctrl (
        .clk(clk), .rst_n(rst_n), .mech_en(mech_en),
        .sp_wr_en(sp_wr_en), .sp_wr_lvl(sp_wr_lvl), .sp_wr_data(sp_wr_data),
        .dlv_req(dlv_req), .dlv_lvl(dlv_lvl), .dlv_nmi(dlv_nmi),
        .ret_req(ret_req), .ret_to_user(ret_to_user), .ret_nmi_unblk(ret_nmi_unblk),
        .gs_swap_req(gs_swap_req), .kgs_load_req(kgs_load_req),
        .kgs_load_data(kgs_load_data),
        .in_user(in_user), .cur_lvl(cur_lvl), .cur_sp(cur_sp),
        .gs_base(gs_base), .kgs_base(kgs_base), .nmi_blocked(nmi_blocked),
        .flt_undef(flt_undef), .flt_overflow(flt_overflow), .flt_return(flt_return)
    );

    typedef struct packed {
        logic        is_ret;
        logic [1:0]  lvl;
        logic        nmi;
        logic        usr;
        logic        unblk;
        logic        e_user;
        logic [1:0]  e_lvl;
        logic [15:0] e_sp;
        logic        e_nmi;
        logic        e_ovf;
        logic        e_retf;
    } vec_t;

    // level registers: 1 -> 0x100, 2 -> 0x200, 3 -> 0x300
    localparam vec_t TBL [NVEC] = '{
        '{1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 16'h0100, 1'b0, 1'b0, 1'b0},
        '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 16'h0100, 1'b1, 1'b0, 1'b0},
        '{1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 16'h0300, 1'b1, 1'b0, 1'b0},
        '{1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 16'h0300, 1'b1, 1'b0, 1'b0},
        '{1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 16'h0300, 1'b1, 1'b1, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 16'h0300, 1'b1, 1'b0, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 16'h0100, 1'b0, 1'b0, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 16'h0100, 1'b0, 1'b0, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1},
        '{1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 16'h0200, 1'b1, 1'b0, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // one-cycle request pulse; results are sampled at the following falling edge
    task automatic drive(input logic dv, input logic [1:0] lv, input logic nm,
                         input logic rt, input logic us, input logic ub,
                         input logic sw, input logic ld, input logic [GS_W-1:0] ldd);
        @(negedge clk);
        dlv_req = dv; dlv_lvl = lv; dlv_nmi = nm;
        ret_req = rt; ret_to_user = us; ret_nmi_unblk = ub;
        gs_swap_req = sw; kgs_load_req = ld; kgs_load_data = ldd;
        @(negedge clk);
        dlv_req = 0; ret_req = 0; gs_swap_req = 0; kgs_load_req = 0;
        dlv_nmi = 0; ret_to_user = 0; ret_nmi_unblk = 0;
    endtask

    task automatic prog_sp(input logic [1:0] lv, input logic [SP_W-1:0] v);
        @(negedge clk);
        sp_wr_en = 1; sp_wr_lvl = lv; sp_wr_data = v;
        @(negedge clk);
        sp_wr_en = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 ring", in_user, 0);
        check("R1 lvl", cur_lvl, 0);
        check("R1 sp", cur_sp, 0);
        check("R1 gs", gs_base, 0);
        check("R1 kgs", kgs_base, 0);
        check("R1 nmi", nmi_blocked, 0);
        check("R1 faults", {flt_undef, flt_overflow, flt_return}, 0);
        drive(0, 0, 0, 1, 0, 0, 0, 0, 0);
        check("R1 empty stack return fault R10", flt_return, 1);

        prog_sp(2'd1, 32'h100);
        prog_sp(2'd2, 32'h200);
        prog_sp(2'd3, 32'h300);

        // table of nested deliveries and returns
        for (int i = 0; i < NVEC; i++) begin
            if (TBL[i].is_ret)
                drive(0, 0, 0, 1, TBL[i].usr, TBL[i].unblk, 0, 0, 0);
            else
                drive(1, TBL[i].lvl, TBL[i].nmi, 0, 0, 0, 0, 0, 0);
            check($sformatf("R4/R5 ring v%0d", i), in_user, TBL[i].e_user);
            check($sformatf("R2/R3 lvl v%0d", i), cur_lvl, TBL[i].e_lvl);
            check($sformatf("R2/R3 sp v%0d", i), cur_sp, 64'(TBL[i].e_sp));
            check($sformatf("R6 nmi v%0d", i), nmi_blocked, TBL[i].e_nmi);
            check($sformatf("R9 ovf v%0d", i), flt_overflow, TBL[i].e_ovf);
            check($sformatf("R10 retf v%0d", i), flt_return, TBL[i].e_retf);
        end

        // GS handling across transitions
        do_reset();
        drive(0, 0, 0, 0, 0, 0, 0, 1, 32'hAAAA);
        check("R8 kgs loaded", kgs_base, 32'hAAAA);
        check("R8 gs untouched", gs_base, 0);
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R4 super dlv gs", gs_base, 0);
        check("R4 super dlv kgs", kgs_base, 32'hAAAA);
        check("R2 same level sp kept", cur_sp, 0);
        drive(0, 0, 0, 1, 1, 0, 0, 0, 0);
        check("R5 to user ring", in_user, 1);
        check("R5 to user gs", gs_base, 32'hAAAA);
        check("R5 to user kgs", kgs_base, 0);
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R4 user dlv ring", in_user, 0);
        check("R4 user dlv gs", gs_base, 0);
        check("R4 user dlv kgs", kgs_base, 32'hAAAA);
        drive(0, 0, 0, 1, 0, 0, 0, 0, 0);
        check("R5 to super ring", in_user, 0);
        check("R5 to super gs", gs_base, 0);
        mech_en = 1;
        drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R7 undef pulse", flt_undef, 1);
        check("R7 gs frozen", gs_base, 0);
        check("R7 kgs frozen", kgs_base, 32'hAAAA);
        mech_en = 0;
        drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R7 disabled swap gs", gs_base, 32'hAAAA);
        check("R7 disabled no fault", flt_undef, 0);
        mech_en = 1;
        drive(0, 0, 0, 0, 0, 0, 0, 1, 32'h5555);
        check("R8 load kgs", kgs_base, 32'h5555);
        check("R8 load keeps gs", gs_base, 32'hAAAA);

        // level register programming
        prog_sp(2'd2, 32'h777);
        check("R12 write keeps sp", cur_sp, 0);
        drive(1, 2'd2, 0, 0, 0, 0, 0, 0, 0);
        check("R12 programmed sp used", cur_sp, 32'h777);

        // priority among simultaneous requests
        drive(1, 2'd3, 0, 1, 1, 1, 1, 1, 32'h9999);
        check("R11 delivery wins lvl", cur_lvl, 3);
        check("R11 load ignored", kgs_base, 32'h5555);
        check("R11 swap ignored", {flt_undef, flt_return}, 0);
        drive(0, 0, 0, 1, 0, 0, 1, 1, 32'h1234);
        check("R11 return wins lvl", cur_lvl, 2);
        check("R11 return wins load ignored", kgs_base, 32'h5555);

        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule